// File: doc/BRIEF.md
# Scan-interval sample decimator

This block sits between a sample FIFO and whatever consumes the samples. The converter runs from one pacer at a fixed rate. A slower scan rate is obtained by keeping one scan and throwing away the extra whole scans that follow it. Software programs four things: the scan length N (channels per scan), a scan delay D, a scan count and an unbounded flag. The block then takes the incoming stream in groups of N·(1+D) samples. It passes the first N samples of each group downstream and consumes the rest without forwarding them.

A down-counter limits the acquisition. It is loaded with scans·N·(1+D) raw pacer samples. It counts every accepted sample, whether kept or dropped. When it reaches zero, an end-of-acquisition flag rises. In unbounded mode the counter plays no part and the stream runs until the next restart.

Both sides use valid/ready handshakes. A kept sample is handed through combinationally. A dropped sample is taken even while the consumer stalls. A start pulse latches the configuration and restarts both counters.

Top module: `scan_decimator`

## Requirements
- R1: After reset and before the first start pulse, in_ready, out_valid and eoa are all 0.
- R2: The config inputs are captured only in the start cycle. Changing them afterwards has no effect on forwarding or on the stop point until the next start.
- R3: Accepted samples are numbered k = 0, 1, … from the start. Sample k is forwarded when (k mod N·(1+D)) < N and is dropped otherwise. Over a counted run, exactly scans·N samples are forwarded.
- R4: With D = 0, every accepted sample is forwarded.
- R5: While out_valid is 1, out_data equals in_data, so forwarded samples keep their order and value.
- R6: While the current sample is to be kept and out_ready is 0, in_ready is 0, so no kept sample is lost. A sample that is to be dropped is accepted with in_ready = 1 whatever out_ready is.
- R7: In counted mode, eoa rises in the cycle after the scans·N·(1+D)-th accepted sample.
- R8: Once eoa is 1, in_ready is 1, out_valid is 0, and eoa holds until the next start.
- R9: In unbounded mode, eoa stays 0 however many samples pass.
- R10: A scan length of 0 is taken as 1, and a scan length above MAX_CH is taken as MAX_CH.
- R11: A counted start with a scan count of 0 raises eoa in the first cycle after the start.
- R12: In the start cycle, in_ready and out_valid are 0. A start restarts the group position at 0 even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: latch configuration and reload counters |
| cfg_nchan | input | CH_W | Channels per scan (N) |
| cfg_delay | input | DELAY_W | Scan delay (D) |
| cfg_scans | input | SCAN_CNT_W | Number of scans in counted mode |
| cfg_unbounded | input | 1 | 1: run with no stop count |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle when valid |
| in_data | input | SAMPLE_W | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | SAMPLE_W | Output sample |
| eoa | output | 1 | End of acquisition |

## Verification
The bench sweeps N from 1 to 5 against D from 0 to 3, over two scans each. The data carries a per-index tag, so any slip in the kept/dropped boundary shows up as a wrong value or a wrong count.

Input valid and output ready are both throttled on independent patterns. Under these patterns, a lost kept sample is caught, and so is a dropped sample that wrongly waits for the consumer.

Separate runs cover four further cases:
- the unbounded flag, with the stop count scrambled;
- clamped scan lengths of 0 and 20;
- a zero scan count;
- a restart in the middle of a run, which shows whether the group position and the stop count are reloaded or carried over.

// File: rtl/scan_dec_pkg.sv
package scan_dec_pkg;

  // Clamp a requested scan length into 1..max_ch.
  function automatic int unsigned clamp_chan(int unsigned n, int unsigned max_ch);
    if (n == 0) return 1;
    if (n > max_ch) return max_ch;
    return n;
  endfunction

  // Samples per group: one kept scan plus d discarded scans.
  function automatic int unsigned group_len(int unsigned n, int unsigned d);
    return n * (d + 1);
  endfunction

  // Raw pacer samples consumed by a counted run.
  function automatic int unsigned stop_total(int unsigned scans, int unsigned n,
                                             int unsigned d);
    return scans * group_len(n, d);
  endfunction

endpackage

// File: rtl/scan_dec_cfg.sv
module scan_dec_cfg #(
  parameter int MAX_CH     = 16,
  parameter int CH_W       = 5,
  parameter int DELAY_W    = 8,
  parameter int SCAN_CNT_W = 16,
  parameter int POS_W      = CH_W + DELAY_W,
  parameter int STOP_W     = SCAN_CNT_W + POS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CH_W-1:0]       nchan_i,
  input  logic [DELAY_W-1:0]    delay_i,
  input  logic [SCAN_CNT_W-1:0] scans_i,
  output logic [CH_W-1:0]       nchan_q,
  output logic [POS_W-1:0]      group_q,
  output logic [STOP_W-1:0]     stop_load
);
  logic [31:0]      n_eff32, grp32, tot32;
  logic [CH_W-1:0]  n_eff;

  always_comb begin
    n_eff32   = scan_dec_pkg::clamp_chan(32'(nchan_i), MAX_CH);
    n_eff     = n_eff32[CH_W-1:0];
    grp32     = scan_dec_pkg::group_len(32'(n_eff), 32'(delay_i));
    tot32     = scan_dec_pkg::stop_total(32'(scans_i), 32'(n_eff), 32'(delay_i));
    stop_load = tot32[STOP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nchan_q <= CH_W'(1);
      group_q <= POS_W'(1);
    end else if (load) begin
      nchan_q <= n_eff;
      group_q <= grp32[POS_W-1:0];
    end
  end
endmodule

// File: rtl/scan_dec_pos.sv
module scan_dec_pos #(
  parameter int CH_W    = 5,
  parameter int DELAY_W = 8,
  parameter int POS_W   = CH_W + DELAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CH_W-1:0]  nchan,
  input  logic [POS_W-1:0] group_len,
  output logic             keep,
  output logic             wrap
);
  logic [POS_W-1:0] pos;

  assign keep = pos < {{DELAY_W{1'b0}}, nchan};
  assign wrap = step && (pos == group_len - POS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (clear) pos <= '0;
    else if (step)  pos <= wrap ? '0 : pos + POS_W'(1);
  end
endmodule

// File: rtl/scan_dec_stop.sv
module scan_dec_stop #(
  parameter int STOP_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STOP_W-1:0] load_val,
  input  logic              load_unb,
  input  logic              step,
  output logic              unb_q,
  output logic              done
);
  logic [STOP_W-1:0] remain;
  logic              last_step;

  assign last_step = step && !unb_q && !done && (remain == STOP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      unb_q  <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      remain <= load_val;
      unb_q  <= load_unb;
      done   <= !load_unb && (load_val == '0);
    end else if (step && !unb_q && !done) begin
      remain <= remain - STOP_W'(1);
      if (last_step) done <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_decimator.sv
module scan_decimator #(
  parameter int SAMPLE_W   = 16,
  parameter int MAX_CH     = 16,
  parameter int DELAY_W    = 8,
  parameter int SCAN_CNT_W = 16,
  localparam int CH_W      = $clog2(MAX_CH + 1),
  localparam int POS_W     = CH_W + DELAY_W,
  localparam int STOP_W    = SCAN_CNT_W + POS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CH_W-1:0]       cfg_nchan,
  input  logic [DELAY_W-1:0]    cfg_delay,
  input  logic [SCAN_CNT_W-1:0] cfg_scans,
  input  logic                  cfg_unbounded,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SAMPLE_W-1:0]   in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SAMPLE_W-1:0]   out_data,
  output logic                  eoa
);
  logic              running;
  logic              keep;
  logic              wrap;
  logic              step;
  logic              unb_q;
  logic [CH_W-1:0]   nchan_q;
  logic [POS_W-1:0]  group_q;
  logic [STOP_W-1:0] stop_load;

  scan_dec_cfg #(.MAX_CH(MAX_CH), .CH_W(CH_W), .DELAY_W(DELAY_W),
                 .SCAN_CNT_W(SCAN_CNT_W), .POS_W(POS_W), .STOP_W(STOP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start),
    .nchan_i(cfg_nchan), .delay_i(cfg_delay), .scans_i(cfg_scans),
    .nchan_q(nchan_q), .group_q(group_q), .stop_load(stop_load)
  );

  scan_dec_pos #(.CH_W(CH_W), .DELAY_W(DELAY_W), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(step),
    .nchan(nchan_q), .group_len(group_q), .keep(keep), .wrap(wrap)
  );

  scan_dec_stop #(.STOP_W(STOP_W)) u_stop (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(stop_load),
    .load_unb(cfg_unbounded), .step(step), .unb_q(unb_q), .done(eoa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     running <= 1'b0;
    else if (start) running <= 1'b1;
  end

  assign in_ready  = running && !start && (eoa || !keep || out_ready);
  assign out_valid = running && !start && !eoa && keep && in_valid;
  assign out_data  = in_data;
  assign step      = in_valid && in_ready && !eoa;
endmodule

// File: rtl/scan_decimator_chk.sv
module scan_decimator_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic running,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic eoa,
  input logic unb_q,
  input logic wrap
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!in_ready && !out_valid && !eoa));

  assert_no_kept_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_done_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoa |-> (!out_valid && (in_ready || start)));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoa && !start) |=> eoa);

  assert_unbounded_never_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unb_q |-> !eoa);

  assert_start_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!in_ready && !out_valid && !wrap));
endmodule

bind scan_decimator scan_decimator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .eoa(eoa), .unb_q(unb_q), .wrap(wrap)
);

// File: tb/scan_decimator_test.sv
module scan_decimator_test;
  localparam int SW = 16, MAXC = 16, DW = 4, SCW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] cfg_nchan = '0;
  logic [DW-1:0] cfg_delay = '0;
  logic [SCW-1:0] cfg_scans = '0;
  logic cfg_unbounded = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, eoa;
  logic [SW-1:0] in_data = '0, out_data;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  scan_decimator #(.SAMPLE_W(SW), .MAX_CH(MAXC), .DELAY_W(DW), .SCAN_CNT_W(SCW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_nchan(cfg_nchan),
    .cfg_delay(cfg_delay), .cfg_scans(cfg_scans), .cfg_unbounded(cfg_unbounded),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .eoa(eoa)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Start pulse, then scramble the config inputs (R2).
  task automatic do_start(int n, int d, int s, bit u);
    @(negedge clk);
    cfg_nchan = 5'(n); cfg_delay = DW'(d); cfg_scans = SCW'(s);
    cfg_unbounded = u; start = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R12 in_ready in start cycle", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R12 out_valid in start cycle", int'(out_valid), 0);
    @(negedge clk);
    start = 1'b0;
    cfg_nchan = 5'd7; cfg_delay = DW'(9); cfg_scans = SCW'(99); cfg_unbounded = ~u;
  endtask

  task automatic run_stream(int n, int d, int s, bit u, int max_k, int seed, string tag);
    int grp = n * (d + 1);
    int total = s * grp;
    int k = 0, fwd = 0, post = 0, cyc = 0;
    bit dexp = !u && (total == 0);
    bit ekeep, eov, eir;
    while (post < 3 && k < max_k) begin
      in_data   = SW'(k * 37 + seed * 3 + (dexp ? 1000 + post : 0));
      out_ready = ((cyc * 5 + seed) % 3) != 0;
      in_valid  = (cyc % 7) != 6;
      cyc++;
      #1;
      ekeep = !dexp && ((k % grp) < n);
      eov   = in_valid && ekeep;
      eir   = dexp || !ekeep || out_ready;
      chk(eoa == dexp, {tag, u ? " R9 eoa" : " R7 eoa"}, int'(eoa), int'(dexp));
      chk(out_valid == eov, {tag, dexp ? " R8 out_valid" : " R3 out_valid"},
          int'(out_valid), int'(eov));
      chk(in_ready == eir, {tag, ekeep ? " R6 in_ready" : " R3 in_ready"},
          int'(in_ready), int'(eir));
      if (out_valid)
        chk(out_data == in_data, {tag, " R5 data"}, int'(out_data), int'(in_data));
      if (in_valid && in_ready) begin
        if (dexp) post++;
        else begin
          if (ekeep) fwd++;
          k++;
          if (!u && k == total) dexp = 1'b1;
        end
      end
      @(negedge clk);
    end
    if (!u && k == total)
      chk(fwd == s * n, {tag, " R3 forwarded count"}, fwd, s * n);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: idle after reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R1 in_ready idle", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R1 out_valid idle", int'(out_valid), 0);
    chk(eoa == 1'b0, "R1 eoa idle", int'(eoa), 0);

    // R3/R4 sweep; config scrambled after each start (R2)
    for (int n = 1; n <= 5; n++)
      for (int d = 0; d <= 3; d++) begin
        do_start(n, d, 2, 1'b0);
        run_stream(n, d, 2, 1'b0, 1000, n * 4 + d, d == 0 ? "R4 R2" : "R3 R2");
      end

    // R9 unbounded
    do_start(3, 2, 1, 1'b1);
    run_stream(3, 2, 1, 1'b1, 90, 5, "R9");

    // R10 clamping
    do_start(0, 1, 2, 1'b0);
    run_stream(1, 1, 2, 1'b0, 1000, 7, "R10 low");
    do_start(20, 1, 1, 1'b0);
    run_stream(16, 1, 1, 1'b0, 1000, 8, "R10 high");

    // R11 zero scans
    do_start(2, 1, 0, 1'b0);
    run_stream(2, 1, 0, 1'b0, 1000, 9, "R11");

    // R12 restart mid-run
    do_start(4, 1, 3, 1'b0);
    run_stream(4, 1, 3, 1'b0, 5, 10, "R12 partial");
    do_start(2, 2, 2, 1'b0);
    run_stream(2, 2, 2, 1'b0, 1000, 11, "R12 restart");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule